// File: doc/BRIEF.md
# Relocatable Configuration Port Decoder

This block sits on the host I/O address path of a multi-function peripheral controller. It decodes an index/data register pair, called the configuration port, through which software selects and programs the controller's logical devices. The index port's address comes from a strap sampled during reset. Software can later move the port to any even address by writing two global configuration registers. The data port always sits one byte above the index port.

The block also holds a programmable base address for each logical device that owns an I/O window. It raises that device's chip-select when a host cycle falls inside the window. For the MIDI device, the two bytes of the window are split into a data select and a status/command select. Software can require the upper four address bits to be zero for any decode to match. Chip-selects and read data are combinational from the current address and strobes. Register writes take effect at the clock edge that ends the write cycle.

Top module: `cfgPortDecoder`

## Requirements
- R1: During reset (rstN low, synchronous) the index register, the selected device number, the global qualifier bit and every device base are cleared. The index port address becomes 0x002E when strapSel is 0 and 0x004E when strapSel is 1.
- R2: A write to the index port stores the data byte as the current index, and a read of the index port returns it. A read or write at the index port address plus 1 (the data port) reaches the register named by the current index.
- R3: Writing index 0x26 through the data port replaces the port address low byte with bit 0 forced to 0. Writing index 0x27 replaces the high byte. Both registers read back. The port moves at the edge that ends the write, so the writing cycle itself still decodes at the old address.
- R4: Index 0x07 holds the selected device number. With device 0x0B selected, index 0x60 holds base bits 15:8 and index 0x61 holds base bits 7:0, with bit 0 forced to 0. Both read back, and the base is visible on devBase.
- R5: A device window chip-select rises only for a device that owns a window, during a read or write strobe, and only when its base lies within 0x0100 to 0x0FFE inclusive and address bits 11:1 equal base bits 11:1.
- R6: Bit 6 of index 0x24 is the upper-address qualifier. When it is 1, the configuration port and the device windows match only if address bits 15:12 are zero. When it is 0, those bits are ignored. The other bits of 0x24 read as 0.
- R7: midiDataCs is asserted for a window hit on the 0x0B device at an even address (offset +0). midiStatCs is asserted for a hit at an odd address (offset +1). The two are never asserted together.
- R8: Indices not listed above read 0x00 and ignore writes. Indices 0x60 and 0x61 count as unlisted when the selected device is not 0x0B; device 0x0C owns no window.
- R9: When an access hits the configuration port, no device window chip-select is asserted, even if a window covers the same address.
- R10: Without a read or write strobe, no chip-select is asserted and hostRdData is 0x00. hostRdData is also 0x00 on any cycle that is not a configuration port read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| strapSel | input | 1 | Strap choosing the port address loaded at reset |
| hostAddr | input | 16 | Host I/O address |
| hostRd | input | 1 | Read strobe |
| hostWr | input | 1 | Write strobe |
| hostWrData | input | 8 | Write data |
| hostRdData | output | 8 | Read data from the configuration port |
| cfgIndex | output | 8 | Current index register |
| curLdn | output | 8 | Selected logical device number |
| cfgPortCs | output | 1 | Index or data port hit |
| devBase | output | 32 | Base address of each device, 16 bits per device, device 0 lowest |
| devCs | output | 2 | Window chip-select per device |
| midiDataCs | output | 1 | MIDI data byte select |
| midiStatCs | output | 1 | MIDI status/command byte select |

## Verification
Two events can land in the same cycle: a data-port write that moves a decode target (the port address, or a device base), and the decode of the cycle that carries that write. The bench provokes this by relocating the port in two steps. The first step parks the port at 0x0000. The second moves it onto a live device window at 0x0200. At every step the behavioural model predicts the old address for the write cycle and the new one from the following cycle. The move onto the window also shows the port taking precedence over the window.

// File: rtl/cfgdec_pkg.sv
package cfgdec_pkg;
  localparam logic [7:0] IDX_LDN     = 8'h07;
  localparam logic [7:0] IDX_GLOBAL  = 8'h24;
  localparam logic [7:0] IDX_PORT_LO = 8'h26;
  localparam logic [7:0] IDX_PORT_HI = 8'h27;
  localparam logic [7:0] IDX_BASE_HI = 8'h60;
  localparam logic [7:0] IDX_BASE_LO = 8'h61;

  localparam int QUAL_BIT = 6;
  localparam int DEC_BITS = 12;

  localparam logic [15:0] PORT_STRAP0 = 16'h002E;
  localparam logic [15:0] PORT_STRAP1 = 16'h004E;
  localparam logic [15:0] WIN_MIN     = 16'h0100;
  localparam logic [15:0] WIN_MAX     = 16'h0FFE;

  typedef struct packed {
    logic wrLdn;
    logic wrGlobal;
    logic wrPortLo;
    logic wrPortHi;
    logic wrBaseHi;
    logic wrBaseLo;
    logic rdIndex;
    logic rdData;
  } cfgStrobes_t;
endpackage

// File: rtl/cfgCtrl.sv
module cfgCtrl
  import cfgdec_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] hostAddr,
  input  logic        hostRd,
  input  logic        hostWr,
  input  logic [7:0]  hostWrData,
  input  logic [15:0] cfgBase,
  input  logic        qualUpper,
  output cfgStrobes_t strb,
  output logic [7:0]  cfgIndex,
  output logic        cfgPortCs,
  output logic        upperOk,
  output logic        anyStb
);
  logic portMatch;
  logic idxHit;
  logic datHit;
  logic datWr;

  always_comb begin
    anyStb    = hostRd | hostWr;
    upperOk   = !qualUpper || (hostAddr[15:DEC_BITS] == '0);
    portMatch = upperOk && (hostAddr[DEC_BITS-1:1] == cfgBase[DEC_BITS-1:1]);
    idxHit    = anyStb && portMatch && !hostAddr[0];
    datHit    = anyStb && portMatch && hostAddr[0];
    cfgPortCs = idxHit | datHit;
    datWr     = datHit && hostWr;
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      cfgIndex <= '0;
    else if (idxHit && hostWr)
      cfgIndex <= hostWrData;
  end

  always_comb begin
    strb          = '0;
    strb.wrLdn    = datWr && (cfgIndex == IDX_LDN);
    strb.wrGlobal = datWr && (cfgIndex == IDX_GLOBAL);
    strb.wrPortLo = datWr && (cfgIndex == IDX_PORT_LO);
    strb.wrPortHi = datWr && (cfgIndex == IDX_PORT_HI);
    strb.wrBaseHi = datWr && (cfgIndex == IDX_BASE_HI);
    strb.wrBaseLo = datWr && (cfgIndex == IDX_BASE_LO);
    strb.rdIndex  = idxHit && hostRd;
    strb.rdData   = datHit && hostRd;
  end

  // R10
  noStrobeNoCs_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(hostRd || hostWr) |-> !cfgPortCs);

  // R8
  wrOneHot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrLdn, strb.wrGlobal, strb.wrPortLo, strb.wrPortHi,
              strb.wrBaseHi, strb.wrBaseLo}));

  // R2
  idxWrite_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgPortCs && hostWr && !hostAddr[0]) |=> (cfgIndex == $past(hostWrData)));
endmodule

// File: rtl/cfgDatapath.sv
module cfgDatapath
  import cfgdec_pkg::*;
#(
  parameter int                NDEV      = 2,
  parameter logic [7:0]        FIRST_LDN = 8'h0B,
  parameter logic [NDEV-1:0]   WIN_MASK  = 2'b01
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               strapSel,
  input  cfgStrobes_t        strb,
  input  logic [7:0]         wrData,
  input  logic [7:0]         cfgIndex,
  input  logic [15:0]        hostAddr,
  input  logic               upperOk,
  input  logic               cfgHit,
  input  logic               anyStb,
  output logic [15:0]        cfgBase,
  output logic               qualUpper,
  output logic [7:0]         curLdn,
  output logic [7:0]         rdData,
  output logic [NDEV*16-1:0] devBase,
  output logic [NDEV-1:0]    devCs
);
  logic [15:0]     baseQ [NDEV];
  logic [NDEV-1:0] selVec;
  logic [NDEV-1:0] inRange;
  logic [15:0]     selBase;
  logic            selAny;
  logic [7:0]      regRd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curLdn    <= '0;
      qualUpper <= 1'b0;
      cfgBase   <= strapSel ? PORT_STRAP1 : PORT_STRAP0;
    end else begin
      if (strb.wrLdn)    curLdn       <= wrData;
      if (strb.wrGlobal) qualUpper    <= wrData[QUAL_BIT];
      if (strb.wrPortLo) cfgBase[7:0] <= {wrData[7:1], 1'b0};
      if (strb.wrPortHi) cfgBase[15:8] <= wrData;
    end
  end

  for (genvar i = 0; i < NDEV; i++) begin : gDev
    if (WIN_MASK[i]) begin : gWin
      assign selVec[i] = (curLdn == 8'(FIRST_LDN + i));

      always_ff @(posedge clk) begin
        if (!rstN)
          baseQ[i] <= '0;
        else if (selVec[i] && strb.wrBaseHi)
          baseQ[i][15:8] <= wrData;
        else if (selVec[i] && strb.wrBaseLo)
          baseQ[i][7:0] <= {wrData[7:1], 1'b0};
      end

      assign inRange[i] = (baseQ[i] >= WIN_MIN) && (baseQ[i] <= WIN_MAX);
      assign devCs[i]   = anyStb && !cfgHit && upperOk && inRange[i] &&
                          (hostAddr[DEC_BITS-1:1] == baseQ[i][DEC_BITS-1:1]);

      // R4
      baseLo_chk: assert property (@(posedge clk) disable iff (!rstN)
        (selVec[i] && strb.wrBaseLo) |=> (baseQ[i][7:0] == {$past(wrData[7:1]), 1'b0}));
    end else begin : gNoWin
      assign selVec[i]  = 1'b0;
      assign baseQ[i]   = '0;
      assign inRange[i] = 1'b0;
      assign devCs[i]   = 1'b0;
    end
    assign devBase[i*16 +: 16] = baseQ[i];
  end

  always_comb begin
    selBase = '0;
    selAny  = 1'b0;
    for (int i = 0; i < NDEV; i++) begin
      if (selVec[i]) begin
        selBase = selBase | baseQ[i];
        selAny  = 1'b1;
      end
    end
  end

  always_comb begin
    case (cfgIndex)
      IDX_LDN:     regRd = curLdn;
      IDX_GLOBAL:  regRd = 8'(qualUpper) << QUAL_BIT;
      IDX_PORT_LO: regRd = cfgBase[7:0];
      IDX_PORT_HI: regRd = cfgBase[15:8];
      IDX_BASE_HI: regRd = selAny ? selBase[15:8] : 8'h00;
      IDX_BASE_LO: regRd = selAny ? selBase[7:0] : 8'h00;
      default:     regRd = 8'h00;
    endcase
    if (strb.rdIndex)
      rdData = cfgIndex;
    else if (strb.rdData)
      rdData = regRd;
    else
      rdData = 8'h00;
  end

  // R3
  portHi_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrPortHi |=> (cfgBase[15:8] == $past(wrData)));

  // R3
  portLo_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrPortLo |=> (cfgBase[7:0] == {$past(wrData[7:1]), 1'b0}));
endmodule

// File: rtl/cfgPortDecoder.sv
module cfgPortDecoder
  import cfgdec_pkg::*;
#(
  parameter int              NDEV      = 2,
  parameter logic [7:0]      FIRST_LDN = 8'h0B,
  parameter logic [NDEV-1:0] WIN_MASK  = 2'b01,
  parameter int              MIDI_IDX  = 0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               strapSel,
  input  logic [15:0]        hostAddr,
  input  logic               hostRd,
  input  logic               hostWr,
  input  logic [7:0]         hostWrData,
  output logic [7:0]         hostRdData,
  output logic [7:0]         cfgIndex,
  output logic [7:0]         curLdn,
  output logic               cfgPortCs,
  output logic [NDEV*16-1:0] devBase,
  output logic [NDEV-1:0]    devCs,
  output logic               midiDataCs,
  output logic               midiStatCs
);
  cfgStrobes_t strb;
  logic [15:0] cfgBase;
  logic        qualUpper;
  logic        upperOk;
  logic        anyStb;

  cfgCtrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .hostAddr  (hostAddr),
    .hostRd    (hostRd),
    .hostWr    (hostWr),
    .hostWrData(hostWrData),
    .cfgBase   (cfgBase),
    .qualUpper (qualUpper),
    .strb      (strb),
    .cfgIndex  (cfgIndex),
    .cfgPortCs (cfgPortCs),
    .upperOk   (upperOk),
    .anyStb    (anyStb)
  );

  cfgDatapath #(
    .NDEV     (NDEV),
    .FIRST_LDN(FIRST_LDN),
    .WIN_MASK (WIN_MASK)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strapSel (strapSel),
    .strb     (strb),
    .wrData   (hostWrData),
    .cfgIndex (cfgIndex),
    .hostAddr (hostAddr),
    .upperOk  (upperOk),
    .cfgHit   (cfgPortCs),
    .anyStb   (anyStb),
    .cfgBase  (cfgBase),
    .qualUpper(qualUpper),
    .curLdn   (curLdn),
    .rdData   (hostRdData),
    .devBase  (devBase),
    .devCs    (devCs)
  );

  assign midiDataCs = devCs[MIDI_IDX] && !hostAddr[0];
  assign midiStatCs = devCs[MIDI_IDX] && hostAddr[0];

  // R9
  cfgPrio_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgPortCs |-> (devCs == '0));

  // R7
  midiExcl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({midiDataCs, midiStatCs}));

  // R10
  idleRead_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgPortCs |-> (hostRdData == 8'h00));
endmodule

// File: tb/cfgPortDecoder_test.sv
`timescale 1ns/1ps
module cfgPortDecoder_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        strapSel = 1'b0;
  logic [15:0] hostAddr = '0;
  logic        hostRd = 1'b0;
  logic        hostWr = 1'b0;
  logic [7:0]  hostWrData = '0;
  logic [7:0]  hostRdData;
  logic [7:0]  cfgIndex;
  logic [7:0]  curLdn;
  logic        cfgPortCs;
  logic [31:0] devBase;
  logic [1:0]  devCs;
  logic        midiDataCs;
  logic        midiStatCs;

  always #2 clk = ~clk;

  cfgPortDecoder uut (
    .clk(clk), .rstN(rstN), .strapSel(strapSel), .hostAddr(hostAddr),
    .hostRd(hostRd), .hostWr(hostWr), .hostWrData(hostWrData),
    .hostRdData(hostRdData), .cfgIndex(cfgIndex), .curLdn(curLdn),
    .cfgPortCs(cfgPortCs), .devBase(devBase), .devCs(devCs),
    .midiDataCs(midiDataCs), .midiStatCs(midiStatCs)
  );

  int checks = 0;
  int fails = 0;
  int mIdx, mLdn, mQual, mPort;
  int mBase [2];

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int regRead();
    case (mIdx)
      'h07: return mLdn;
      'h24: return mQual << 6;
      'h26: return mPort & 'hFF;
      'h27: return (mPort >> 8) & 'hFF;
      'h60: return (mLdn == 'h0B) ? ((mBase[0] >> 8) & 'hFF) : 0;
      'h61: return (mLdn == 'h0B) ? (mBase[0] & 'hFF) : 0;
      default: return 0;
    endcase
  endfunction

  task automatic writeReg(int d);
    case (mIdx)
      'h07: mLdn = d;
      'h24: mQual = (d >> 6) & 1;
      'h26: mPort = (mPort & 'hFF00) | (d & 'hFE);
      'h27: mPort = (mPort & 'hFF) | (d << 8);
      'h60: if (mLdn == 'h0B) mBase[0] = (mBase[0] & 'hFF) | (d << 8);
      'h61: if (mLdn == 'h0B) mBase[0] = (mBase[0] & 'hFF00) | (d & 'hFE);
      default: ;
    endcase
  endtask

  // One bus cycle: drive at the falling edge, compare just after, advance model at rising edge.
  task automatic step(int a, bit rd, bit wr, int d, string tag);
    bit any, upOk, hIdx, hDat, hCfg, winHit;
    int expRd, lo, b;
    @(negedge clk);
    hostAddr = a[15:0]; hostRd = rd; hostWr = wr; hostWrData = d[7:0];
    #1;
    any  = rd || wr;
    upOk = (mQual == 0) || (((a >> 12) & 'hF) == 0);
    lo   = a & 'hFFF;
    hIdx = any && upOk && (lo == (mPort & 'hFFE));
    hDat = any && upOk && (lo == ((mPort & 'hFFE) | 1));
    hCfg = hIdx || hDat;
    if (rd && hIdx) expRd = mIdx;
    else if (rd && hDat) expRd = regRead();
    else expRd = 0;
    b = mBase[0];
    winHit = any && !hCfg && upOk && (b >= 'h100) && (b <= 'hFFE) &&
             ((a & 'hFFE) == (b & 'hFFE));
    chk(tag, "hostRdData", int'(hostRdData), expRd);
    chk(tag, "cfgPortCs", int'(cfgPortCs), int'(hCfg));
    chk(tag, "devCs", int'(devCs), int'(winHit));
    chk(tag, "midiDataCs", int'(midiDataCs), int'(winHit && ((a & 1) == 0)));
    chk(tag, "midiStatCs", int'(midiStatCs), int'(winHit && ((a & 1) == 1)));
    chk(tag, "cfgIndex", int'(cfgIndex), mIdx);
    chk(tag, "curLdn", int'(curLdn), mLdn);
    chk(tag, "devBase", int'(devBase), mBase[0] | (mBase[1] << 16));
    @(posedge clk);
    if (wr && hIdx) mIdx = d & 'hFF;
    if (wr && hDat) writeReg(d & 'hFF);
  endtask

  task automatic cfgWr(int idx, int val, string tag);
    int p;
    p = mPort & 'hFFE;
    step(p, 0, 1, idx, tag);
    step(p + 1, 0, 1, val, tag);
  endtask

  task automatic cfgRd(int idx, string tag);
    int p;
    p = mPort & 'hFFE;
    step(p, 0, 1, idx, tag);
    step(p + 1, 1, 0, 0, tag);
  endtask

  task automatic doReset(bit s);
    @(negedge clk);
    rstN = 1'b0; strapSel = s; hostRd = 0; hostWr = 0; hostAddr = '0;
    repeat (3) @(posedge clk);
    mIdx = 0; mLdn = 0; mQual = 0; mBase[0] = 0; mBase[1] = 0;
    mPort = s ? 'h4E : 'h2E;
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog expired, run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset state with strap low
    doReset(0);
    step(0, 0, 0, 0, "R1");
    step('h2E, 1, 0, 0, "R1");
    cfgRd('h26, "R1");
    cfgRd('h27, "R1");
    // R10: no strobe, no selects
    step('h2E, 0, 0, 0, "R10");
    step('h2F, 0, 0, 0, "R10");
    // R4: select device and program base 0x0330
    cfgWr('h07, 'h0B, "R4");
    cfgWr('h60, 'h03, "R4");
    cfgWr('h61, 'h31, "R4");
    cfgRd('h61, "R4");
    cfgRd('h60, "R4");
    // R7: MIDI offsets
    step('h330, 1, 0, 0, "R7");
    step('h331, 0, 1, 'h55, "R7");
    step('h330, 0, 0, 0, "R10");
    step('h332, 1, 0, 0, "R5");
    // R6: upper address qualifier
    step('h1330, 1, 0, 0, "R6");
    step('h102E, 1, 0, 0, "R6");
    cfgWr('h24, 'hFF, "R6");
    cfgRd('h24, "R6");
    step('h1330, 1, 0, 0, "R6");
    step('h102E, 1, 0, 0, "R6");
    step('h0330, 1, 0, 0, "R6");
    cfgWr('h24, 'h00, "R6");
    // R8: unimplemented indices and windowless device
    cfgWr('h30, 'hAA, "R8");
    cfgRd('h30, "R8");
    cfgWr('h07, 'h0C, "R8");
    cfgWr('h60, 'h05, "R8");
    cfgRd('h60, "R8");
    cfgRd('h61, "R8");
    step('h330, 1, 0, 0, "R8");
    cfgWr('h07, 'h0B, "R5");
    // R5: range limits
    cfgWr('h60, 'h00, "R5");
    step('h030, 1, 0, 0, "R5");
    cfgWr('h60, 'h0F, "R5");
    cfgWr('h61, 'hFF, "R5");
    step('hFFE, 1, 0, 0, "R5");
    step('hFFF, 0, 1, 'h12, "R5");
    cfgWr('h60, 'h10, "R5");
    step('h0FE, 1, 0, 0, "R5");
    step('h10FE, 1, 0, 0, "R5");
    // R9: window at 0x0200, then move the port onto it
    cfgWr('h60, 'h02, "R9");
    cfgWr('h61, 'h00, "R9");
    step('h200, 1, 0, 0, "R9");
    // R3: relocation in two steps, old address holds in the writing cycle
    cfgWr('h26, 'h01, "R3");
    step('h2E, 1, 0, 0, "R3");
    step('h000, 1, 0, 0, "R3");
    cfgWr('h27, 'h02, "R3");
    step('h200, 1, 0, 0, "R9");
    step('h201, 1, 0, 0, "R9");
    step('h000, 1, 0, 0, "R3");
    cfgRd('h26, "R3");
    cfgRd('h27, "R3");
    // R2: mixed traffic against the model
    for (int n = 0; n < 400; n++) begin
      int sel, a, d;
      bit rd, wr;
      sel = $urandom % 5;
      case (sel)
        0: a = mPort & 'hFFE;
        1: a = (mPort & 'hFFE) | 1;
        2: a = mBase[0];
        3: a = mBase[0] | 1;
        default: a = $urandom & 'h1FFF;
      endcase
      rd = $urandom % 2;
      wr = !rd && ($urandom % 2);
      case ($urandom % 7)
        0: d = 'h07; 1: d = 'h24; 2: d = 'h60; 3: d = 'h61;
        4: d = 'h0B; 5: d = 'h30; default: d = $urandom & 'hFF;
      endcase
      step(a, rd, wr, d, "R2");
    end
    // R1: reset with strap high
    doReset(1);
    step('h4E, 1, 0, 0, "R1");
    step('h2E, 1, 0, 0, "R1");
    cfgRd('h26, "R1");
    step(0, 0, 0, 0, "R10");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule